// File: doc/BRIEF.md
# Peripheral Sleep Control Unit

This block lets firmware switch the clocks of a group of on-chip peripherals off and on. Firmware writes a request word that holds one sleep bit per peripheral slot. Each slot drives a clock-enable output to its gating cell and a sleep-status bit. Firmware can read back both the request word and the status word through a small register port.

Each slot uses one of two sleep policies, fixed at elaboration by a mask parameter.

- **Absolute** slots stop their clock as soon as the request bit is set.
- **Device-paced** slots wait in a pending state with the clock running. They sleep only once their peripheral signals that it is ready. While asleep, the peripheral may pull its own clock back on through a self-wake input. It goes back to sleep when it is ready again, as long as the request is still set.

Clearing a request bit wakes the slot at once, whatever its policy. The default build has five slots:

| Slot | Peripheral | Policy |
|------|------------|--------|
| 0, 1 | Serial ports | Absolute |
| 2, 3 | Two-wire bus controllers | Device-paced |
| 4 | General-purpose timer | Absolute |

Top module: `periph_sleep_ctrl`

## Requirements
- R1: While reset is held and right after it is released, the request word reads 0, every `clk_en_o` bit is 1 and every `asleep_o` bit is 0.
- R2: In an absolute slot, a write to address 0 that sets the slot's request bit drives its `clk_en_o` to 0 on the cycle after the write. No handshake is involved.
- R3: In a device-paced slot, a set request keeps `clk_en_o` at 1 while `rdy_i` is 0. `clk_en_o` goes to 0 on the cycle after a cycle in which the request is set, `rdy_i` is 1 and `wake_i` is 0. This includes the cycle of the write itself.
- R4: A device-paced slot that is asleep and sees `wake_i` at 1 restores `clk_en_o` to 1 on the next cycle, even though its request bit stays set.
- R5: After a self-wake, the device-paced slot sleeps again once `rdy_i` is 1 and `wake_i` is 0, as long as its request bit is still set.
- R6: Clearing a request bit through a write to address 0 sets that slot's `clk_en_o` to 1 on the next cycle. This holds in both modes and from any state.
- R7: In a device-paced slot, when `wake_i` and `rdy_i` are both 1 in the same cycle, self-wake wins and `clk_en_o` is 1 on the next cycle.
- R8: `reg_rdata` returns the request word when `reg_addr` is 0. It returns the status word when `reg_addr` is 1, where a bit of 1 means that slot's clock enable is off. The read is combinational from the current state. A write with `reg_addr` at 1 changes nothing.
- R9: Absolute slots ignore `rdy_i` and `wake_i`. An asleep absolute slot stays asleep while `wake_i` is pulsed.
- R10: `asleep_o` is always the bitwise inverse of `clk_en_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = request word, 1 = status word |
| reg_wdata | input | N_SLOTS | Write data |
| reg_rdata | output | N_SLOTS | Read data for the selected register |
| rdy_i | input | N_SLOTS | Per-slot ready-to-sleep from the peripheral |
| wake_i | input | N_SLOTS | Per-slot self-wake from the peripheral |
| clk_en_o | output | N_SLOTS | Per-slot clock enable |
| asleep_o | output | N_SLOTS | Per-slot sleep status |

## Verification
Every result is due exactly one clock edge after its stimulus, because the request register and the slot state are each a single flop stage. A write or a `rdy_i`/`wake_i` cycle presented before edge k shows up on `clk_en_o` right after edge k. `reg_rdata` is combinational from that same state, so it is valid in the same cycle.

The bench drives inputs just after a falling edge. It pushes the expected enable word and read word once the next rising edge has passed. The monitor pops and compares them at the following falling edge, so every comparison lands exactly one edge after its stimulus.

// File: rtl/periph_sleep_pkg.sv
package periph_sleep_pkg;

  typedef enum logic [1:0] {
    SLOT_AWAKE   = 2'd0,
    SLOT_PENDING = 2'd1,
    SLOT_ASLEEP  = 2'd2
  } slot_state_t;

  // Next state of one slot; the request is the value taking effect this edge.
  function automatic slot_state_t slot_step(
    input logic        paced,
    input slot_state_t cur,
    input logic        req,
    input logic        rdy,
    input logic        wake
  );
    logic settle;
    settle = rdy & ~wake;   // self-wake outranks ready-to-sleep
    if (!req)
      return SLOT_AWAKE;
    if (!paced)
      return SLOT_ASLEEP;
    case (cur)
      SLOT_AWAKE:   return settle ? SLOT_ASLEEP : SLOT_PENDING;
      SLOT_PENDING: return settle ? SLOT_ASLEEP : SLOT_PENDING;
      SLOT_ASLEEP:  return wake ? SLOT_PENDING : SLOT_ASLEEP;
      default:      return SLOT_AWAKE;
    endcase
  endfunction

  function automatic logic slot_clock_on(input slot_state_t s);
    return s != SLOT_ASLEEP;
  endfunction

endpackage

// File: rtl/psc_request_reg.sv
module psc_request_reg #(
  parameter int N_SLOTS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_req,
  input  logic [N_SLOTS-1:0] wdata,
  output logic [N_SLOTS-1:0] req_next,
  output logic [N_SLOTS-1:0] req_q
);

  always_comb req_next = wr_req ? wdata : req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_next;
  end

endmodule

// File: rtl/psc_slot_fsm.sv
module psc_slot_fsm
  import periph_sleep_pkg::*;
#(
  parameter bit PACED = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        rdy,
  input  logic        wake,
  output slot_state_t state_o,
  output logic        clk_en
);

  slot_state_t state_q, state_d;

  always_comb state_d = slot_step(PACED, state_q, req, rdy, wake);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SLOT_AWAKE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign clk_en  = slot_clock_on(state_q);

endmodule

// File: rtl/psc_read_mux.sv
module psc_read_mux #(
  parameter int N_SLOTS = 5
) (
  input  logic               sel_status,
  input  logic [N_SLOTS-1:0] req_word,
  input  logic [N_SLOTS-1:0] status_word,
  output logic [N_SLOTS-1:0] rdata
);

  always_comb rdata = sel_status ? status_word : req_word;

endmodule

// File: rtl/periph_sleep_ctrl.sv
module periph_sleep_ctrl
  import periph_sleep_pkg::*;
#(
  parameter int               N_SLOTS    = 5,
  parameter logic [N_SLOTS-1:0] PACED_MASK = 5'b01100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [N_SLOTS-1:0] reg_wdata,
  output logic [N_SLOTS-1:0] reg_rdata,
  input  logic [N_SLOTS-1:0] rdy_i,
  input  logic [N_SLOTS-1:0] wake_i,
  output logic [N_SLOTS-1:0] clk_en_o,
  output logic [N_SLOTS-1:0] asleep_o
);

  localparam logic ADDR_REQ = 1'b0;

  logic               req_write;
  logic [N_SLOTS-1:0] req_next;
  logic [N_SLOTS-1:0] req_q;
  logic [N_SLOTS-1:0] en_w;
  slot_state_t        slot_state [N_SLOTS];

  assign req_write = reg_wr && (reg_addr == ADDR_REQ);

  psc_request_reg #(.N_SLOTS(N_SLOTS)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (req_write),
    .wdata    (reg_wdata),
    .req_next (req_next),
    .req_q    (req_q)
  );

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    psc_slot_fsm #(.PACED(PACED_MASK[i])) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_next[i]),
      .rdy     (rdy_i[i]),
      .wake    (wake_i[i]),
      .state_o (slot_state[i]),
      .clk_en  (en_w[i])
    );
  end

  assign clk_en_o = en_w;
  assign asleep_o = ~en_w;

  psc_read_mux #(.N_SLOTS(N_SLOTS)) u_rd (
    .sel_status  (reg_addr),
    .req_word    (req_q),
    .status_word (asleep_o),
    .rdata       (reg_rdata)
  );

endmodule

// File: rtl/periph_sleep_ctrl_chk.sv
module periph_sleep_ctrl_chk #(
  parameter int               N_SLOTS    = 5,
  parameter logic [N_SLOTS-1:0] PACED_MASK = 5'b01100
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_SLOTS-1:0] req_next,
  input logic [N_SLOTS-1:0] rdy_i,
  input logic [N_SLOTS-1:0] wake_i,
  input logic [N_SLOTS-1:0] clk_en_o,
  input logic [N_SLOTS-1:0] asleep_o
);

  AST_STATUS_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_o == ~clk_en_o); // R10

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_chk
    AST_CLEAR_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      !req_next[i] |=> clk_en_o[i]); // R6

    if (!PACED_MASK[i]) begin : g_abs
      AST_ABS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        req_next[i] |=> !clk_en_o[i]); // R2
    end else begin : g_paced
      AST_PACED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_o[i] && !rdy_i[i]) |=> clk_en_o[i]); // R3
      AST_WAKE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i[i] |=> clk_en_o[i]); // R7
      AST_PACED_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_next[i] && rdy_i[i] && !wake_i[i]) |=> !clk_en_o[i]); // R5
    end
  end

endmodule

bind periph_sleep_ctrl periph_sleep_ctrl_chk #(
  .N_SLOTS    (N_SLOTS),
  .PACED_MASK (PACED_MASK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_next (req_next),
  .rdy_i    (rdy_i),
  .wake_i   (wake_i),
  .clk_en_o (clk_en_o),
  .asleep_o (asleep_o)
);

// File: tb/periph_sleep_ctrl_bench.sv
module periph_sleep_ctrl_bench;

  localparam int         N     = 5;
  localparam logic [N-1:0] PACED = 5'b01100;
  localparam time        CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic         reg_addr = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic [N-1:0] rdy_i = '0;
  logic [N-1:0] wake_i = '0;
  logic [N-1:0] clk_en_o;
  logic [N-1:0] asleep_o;

  int compared = 0;
  int mismatched = 0;

  logic [N-1:0] exp_en_q [$];
  logic [N-1:0] exp_rd_q [$];
  string        tag_q    [$];

  // Bench model: sleep flag and "clock back on, waiting" flag per slot.
  logic [N-1:0] m_req   = '0;
  logic [N-1:0] m_sleep = '0;
  logic [N-1:0] m_wait  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_sleep_ctrl #(.N_SLOTS(N), .PACED_MASK(PACED)) u_periph_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rdy_i(rdy_i),
    .wake_i(wake_i), .clk_en_o(clk_en_o), .asleep_o(asleep_o)
  );

  task automatic check(input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, predict, push expectation.
  task automatic step(input logic wr, input logic addr, input logic [N-1:0] wd,
                      input logic [N-1:0] rdy, input logic [N-1:0] wk,
                      input string tag);
    logic [N-1:0] nreq;
    @(negedge clk); #1;
    reg_wr = wr; reg_addr = addr; reg_wdata = wd; rdy_i = rdy; wake_i = wk;
    nreq = (wr && !addr) ? wd : m_req;
    for (int i = 0; i < N; i++) begin
      if (!nreq[i]) begin
        m_sleep[i] = 1'b0; m_wait[i] = 1'b0;
      end else if (!PACED[i]) begin
        m_sleep[i] = 1'b1;
      end else if (wk[i]) begin
        m_sleep[i] = 1'b0; m_wait[i] = 1'b1;
      end else if (rdy[i]) begin
        m_sleep[i] = 1'b1; m_wait[i] = 1'b0;
      end else if (!m_sleep[i]) begin
        m_wait[i] = 1'b1;
      end
    end
    m_req = nreq;
    @(posedge clk);
    exp_en_q.push_back(~m_sleep);
    exp_rd_q.push_back(addr ? m_sleep : m_req);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare at the falling edge after the result edge.
  always @(negedge clk) begin
    if (exp_en_q.size() > 0) begin
      logic [N-1:0] e_en, e_rd;
      string t;
      e_en = exp_en_q.pop_front();
      e_rd = exp_rd_q.pop_front();
      t    = tag_q.pop_front();
      check(t, clk_en_o, e_en, "clk_en_o");
      check(t, reg_rdata, e_rd, "reg_rdata");
      check("R10", asleep_o, ~clk_en_o, "asleep_o");
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", clk_en_o, '1, "clk_en_o in reset");
    check("R1", asleep_o, '0, "asleep_o in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", reg_rdata, '0, "request word after reset");
    check("R1", clk_en_o, '1, "clk_en_o after reset");

    step(1, 0, 5'b00001, '0, '0, "R2 absolute serial slot sleeps");
    step(0, 1, '0, '0, '0, "R8 status read");
    step(1, 1, 5'b11111, '0, '0, "R8 write to status ignored");
    step(0, 0, '0, '0, '0, "R8 request word unchanged");
    step(0, 0, '0, '0, 5'b11111, "R9 absolute slot ignores wake");
    step(0, 0, '0, 5'b11111, '0, "R9 absolute slot ignores ready");
    step(1, 0, 5'b00101, '0, '0, "R3 paced slot pending");
    step(0, 0, '0, '0, '0, "R3 paced slot still pending");
    step(0, 1, '0, 5'b00100, '0, "R3 paced slot sleeps on ready");
    step(0, 0, '0, '0, 5'b00100, "R4 self-wake restores clock");
    step(0, 0, '0, 5'b00100, '0, "R5 back to sleep while requested");
    step(0, 0, '0, 5'b00100, 5'b00100, "R7 wake beats ready from sleep");
    step(0, 0, '0, 5'b00100, 5'b00100, "R7 wake beats ready while pending");
    step(0, 1, '0, 5'b00100, '0, "R5 sleeps again");
    step(1, 0, 5'b00100, '0, '0, "R6 clear absolute slot");
    step(1, 0, 5'b00000, '0, '0, "R6 clear asleep paced slot");
    step(1, 0, 5'b01000, 5'b01000, '0, "R3 ready on write cycle");
    step(1, 0, 5'b11011, '0, '0, "R2 timer and serial slots sleep");
    step(0, 1, '0, '0, '0, "R8 status of mixed sleep");
    step(1, 0, 5'b11000, '0, '0, "R6 partial clear");
    step(1, 0, 5'b00000, '0, '0, "R6 clear all");

    @(negedge clk); @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule